// File: doc/BRIEF.md
# Compare-Set and Trap Unit

This block is the relational core of a small three-address integer pipeline. One engine evaluates ten relations between two 32-bit operands and serves three operation classes. A set operation writes a full word holding 0 or 1. A trap operation raises a trap request when the relation holds. A branch operation tests one register against zero and reports whether the branch is taken. The second operand is either a register value or a 16-bit immediate. The relation kind selects how that immediate is widened.

Decode, the register file and trap handling sit outside the block. The surrounding pipeline presents the operation class, the condition code, the immediate controls and the operands. One clock edge later it reads the registered result, trap and branch outputs.

Top module: `cmpset_unit`

## Requirements
- R1: For a set operation (class code 0), `res_o` is the full 32-bit word 1 when the relation holds and the word 0 when it does not.
- R2: Condition codes are eq=0, ne=1, lt=2, le=3, gt=4, ge=5, ltu=6, leu=7, gtu=8, geu=9. Codes 10 to 15 never hold.
- R3: Codes 2 to 5 compare the operands as two's-complement signed values.
- R4: Codes 6 to 9 compare the operands as raw unsigned bit patterns.
- R5: With `imm_en_i` high, the signed orderings (codes 2 to 5) use the 16-bit immediate sign-extended to 32 bits, whatever the value of `imm_uns_i`.
- R6: With `imm_en_i` high, the unsigned orderings (codes 6 to 9) use the immediate zero-extended to 32 bits.
- R7: With `imm_en_i` high, eq and ne use the immediate zero-extended when `imm_uns_i` is 1 and sign-extended when it is 0.
- R8: For a branch operation (class code 2), `opa_i` is compared against zero, and `opb_i` and the immediate are ignored. Branch-true is issued as ne (code 1) and branch-false as eq (code 0). `branch_o` is 1 when the relation holds.
- R9: For a trap operation (class code 1), `trap_o` is 1 exactly when the relation holds, and `res_o` is 0.
- R10: `trap_o` is 0 for every class except trap, and `branch_o` is 0 for every class except branch.
- R11: All outputs are registered and appear on the rising edge after the inputs. An active-low asynchronous reset clears every output to 0.
- R12: Class code 3 is a no-operation and drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cls_i | input | 2 | Operation class: 0 set, 1 trap, 2 branch, 3 none |
| cond_i | input | 4 | Relation code, see R2 |
| imm_en_i | input | 1 | Take the second operand from the immediate |
| imm_uns_i | input | 1 | Zero-extend the immediate for eq/ne |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (register form) |
| imm_i | input | 16 | Immediate field |
| res_o | output | 32 | Set result word |
| trap_o | output | 1 | Trap request |
| branch_o | output | 1 | Branch taken |

## Verification
Every output is one register stage away from its inputs. A stimulus applied before a rising edge therefore shows up on `res_o`, `trap_o` and `branch_o` just after that edge. The bench drives inputs on a falling edge and compares outputs on the next falling edge, which falls one rising edge later, so each check sees exactly the result of the stimulus before it. Reset is asynchronous, so the reset check samples the outputs while reset is still held, without waiting for a clock.

// File: rtl/cmpset_pkg.sv
`timescale 1ns/1ps
package cmpset_pkg;

    localparam int CMPSET_COND_W = 4;

    typedef enum logic [1:0] {
        CLS_SET    = 2'd0,
        CLS_TRAP   = 2'd1,
        CLS_BRANCH = 2'd2,
        CLS_NONE   = 2'd3
    } cmpset_cls_e;

    localparam logic [CMPSET_COND_W-1:0] REL_EQ  = 4'd0;
    localparam logic [CMPSET_COND_W-1:0] REL_NE  = 4'd1;
    localparam logic [CMPSET_COND_W-1:0] REL_LT  = 4'd2;
    localparam logic [CMPSET_COND_W-1:0] REL_LE  = 4'd3;
    localparam logic [CMPSET_COND_W-1:0] REL_GT  = 4'd4;
    localparam logic [CMPSET_COND_W-1:0] REL_GE  = 4'd5;
    localparam logic [CMPSET_COND_W-1:0] REL_LTU = 4'd6;
    localparam logic [CMPSET_COND_W-1:0] REL_LEU = 4'd7;
    localparam logic [CMPSET_COND_W-1:0] REL_GTU = 4'd8;
    localparam logic [CMPSET_COND_W-1:0] REL_GEU = 4'd9;

    // Orderings on raw bit patterns
    function automatic logic rel_is_unsigned(input logic [CMPSET_COND_W-1:0] c);
        return (c >= REL_LTU) && (c <= REL_GEU);
    endfunction

    // Equality tests, whose immediate widening is chosen by the caller
    function automatic logic rel_is_equality(input logic [CMPSET_COND_W-1:0] c);
        return (c == REL_EQ) || (c == REL_NE);
    endfunction

endpackage

// File: rtl/cmpset_opsel.sv
`timescale 1ns/1ps
module cmpset_opsel
    import cmpset_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [CMPSET_COND_W-1:0] cond_i,
    input  logic                     zero_ref_i,
    input  logic                     imm_en_i,
    input  logic                     imm_uns_i,
    input  logic [DATA_W-1:0]        reg_b_i,
    input  logic [IMM_W-1:0]         imm_i,
    output logic [DATA_W-1:0]        opnd_o
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic              widen_zero;
    logic [DATA_W-1:0] imm_sext;
    logic [DATA_W-1:0] imm_zext;

    always_comb begin
        // Unsigned orderings always zero-widen; eq/ne follow the flag (R6, R7)
        widen_zero = rel_is_unsigned(cond_i) ||
                     (rel_is_equality(cond_i) && imm_uns_i);
        imm_sext   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        imm_zext   = {{EXT_W{1'b0}}, imm_i};
        if (zero_ref_i) begin
            opnd_o = '0;                      // branch tests against zero (R8)
        end else if (imm_en_i) begin
            opnd_o = widen_zero ? imm_zext : imm_sext;
        end else begin
            opnd_o = reg_b_i;
        end
    end

    // Widened immediate must keep the low field intact
    always_comb begin
        if (imm_en_i && !zero_ref_i) begin
            assert_imm_low_kept_R5: assert (opnd_o[IMM_W-1:0] == imm_i);
        end
    end

endmodule

// File: rtl/cmpset_releng.sv
`timescale 1ns/1ps
module cmpset_releng
    import cmpset_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NCOND  = 2**CMPSET_COND_W
) (
    input  logic [DATA_W-1:0] lhs_i,
    input  logic [DATA_W-1:0] rhs_i,
    output logic [NCOND-1:0]  hit_o
);
    logic same;
    logic s_less;
    logic u_less;

    always_comb begin
        same   = (lhs_i == rhs_i);
        s_less = ($signed(lhs_i) < $signed(rhs_i));
        u_less = (lhs_i < rhs_i);
    end

    for (genvar g = 0; g < NCOND; g++) begin : g_rel
        if (g == int'(REL_EQ)) begin : g_eq
            assign hit_o[g] = same;
        end else if (g == int'(REL_NE)) begin : g_ne
            assign hit_o[g] = !same;
        end else if (g == int'(REL_LT)) begin : g_lt
            assign hit_o[g] = s_less;
        end else if (g == int'(REL_LE)) begin : g_le
            assign hit_o[g] = s_less || same;
        end else if (g == int'(REL_GT)) begin : g_gt
            assign hit_o[g] = !(s_less || same);
        end else if (g == int'(REL_GE)) begin : g_ge
            assign hit_o[g] = !s_less;
        end else if (g == int'(REL_LTU)) begin : g_ltu
            assign hit_o[g] = u_less;
        end else if (g == int'(REL_LEU)) begin : g_leu
            assign hit_o[g] = u_less || same;
        end else if (g == int'(REL_GTU)) begin : g_gtu
            assign hit_o[g] = !(u_less || same);
        end else if (g == int'(REL_GEU)) begin : g_geu
            assign hit_o[g] = !u_less;
        end else begin : g_unused
            assign hit_o[g] = 1'b0;              // codes 10..15 never hold (R2)
        end
    end

    // Complementary pairs must disagree; compound relations must agree with parts
    always_comb begin
        assert_eq_ne_split_R2: assert (hit_o[REL_EQ] != hit_o[REL_NE]);
        assert_lt_ge_split_R3: assert (hit_o[REL_LT] != hit_o[REL_GE]);
        assert_gt_le_split_R3: assert (hit_o[REL_GT] != hit_o[REL_LE]);
        assert_ltu_geu_split_R4: assert (hit_o[REL_LTU] != hit_o[REL_GEU]);
        assert_gtu_leu_split_R4: assert (hit_o[REL_GTU] != hit_o[REL_LEU]);
    end

endmodule

// File: rtl/cmpset_unit.sv
`timescale 1ns/1ps
module cmpset_unit
    import cmpset_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cls_i,
    input  logic [CMPSET_COND_W-1:0] cond_i,
    input  logic                     imm_en_i,
    input  logic                     imm_uns_i,
    input  logic [DATA_W-1:0]        opa_i,
    input  logic [DATA_W-1:0]        opb_i,
    input  logic [IMM_W-1:0]         imm_i,
    output logic [DATA_W-1:0]        res_o,
    output logic                     trap_o,
    output logic                     branch_o
);
    localparam int NCOND = 2**CMPSET_COND_W;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              trap;
        logic              taken;
    } out_state_t;

    out_state_t        out_d;
    out_state_t        out_q;
    logic [DATA_W-1:0] rhs;
    logic [NCOND-1:0]  hits;
    logic              holds;
    logic              is_branch;

    assign is_branch = (cls_i == CLS_BRANCH);

    cmpset_opsel #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) opsel_i (
        .cond_i     (cond_i),
        .zero_ref_i (is_branch),
        .imm_en_i   (imm_en_i),
        .imm_uns_i  (imm_uns_i),
        .reg_b_i    (opb_i),
        .imm_i      (imm_i),
        .opnd_o     (rhs)
    );

    cmpset_releng #(
        .DATA_W (DATA_W),
        .NCOND  (NCOND)
    ) releng_i (
        .lhs_i (opa_i),
        .rhs_i (rhs),
        .hit_o (hits)
    );

    assign holds = hits[cond_i];

    always_comb begin
        out_d = '0;
        unique case (cls_i)
            CLS_SET:    out_d.res   = {{(DATA_W-1){1'b0}}, holds};
            CLS_TRAP:   out_d.trap  = holds;
            CLS_BRANCH: out_d.taken = holds;
            default:    out_d       = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o    = out_q.res;
    assign trap_o   = out_q.trap;
    assign branch_o = out_q.taken;

    assert_set_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_o[DATA_W-1:1] == '0);

    assert_trap_class_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i != CLS_TRAP) |=> !trap_o);

    assert_branch_class_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i != CLS_BRANCH) |=> !branch_o);

    assert_trap_no_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == CLS_TRAP) |=> (res_o == '0));

    assert_none_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == CLS_NONE) |=> (res_o == '0 && !trap_o && !branch_o));

    assert_held_inputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == CLS_SET && cond_i == REL_EQ && !imm_en_i && opa_i == opb_i)
        |=> (res_o[0] == 1'b1));

endmodule

// File: tb/cmpset_unit_tb.sv
`timescale 1ns/1ps
module cmpset_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cls;
    logic [3:0]  cond;
    logic        imm_en;
    logic        imm_uns;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [15:0] imm;
    logic [31:0] res;
    logic        trap;
    logic        br;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cmpset_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cls_i     (cls),
        .cond_i    (cond),
        .imm_en_i  (imm_en),
        .imm_uns_i (imm_uns),
        .opa_i     (opa),
        .opb_i     (opb),
        .imm_i     (imm),
        .res_o     (res),
        .trap_o    (trap),
        .branch_o  (br)
    );

    typedef struct packed {
        logic [1:0]  cls;
        logic [3:0]  cond;
        logic        ie;
        logic        iu;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [31:0] exp_res;
        logic        exp_trap;
        logic        exp_br;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t TBL [NVEC] = '{
        '{2'd0, 4'd2, 1'b0, 1'b0, 32'h8000_0000, 32'h1, 16'h0, 32'h1, 1'b0, 1'b0, 8'd3},          // R3
        '{2'd0, 4'd6, 1'b0, 1'b0, 32'h8000_0000, 32'h1, 16'h0, 32'h0, 1'b0, 1'b0, 8'd4},          // R4
        '{2'd0, 4'd9, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0, 16'h0, 32'h1, 1'b0, 1'b0, 8'd4},          // R4
        '{2'd0, 4'd0, 1'b1, 1'b0, 32'hFFFF_8000, 32'h0, 16'h8000, 32'h1, 1'b0, 1'b0, 8'd7},       // R7
        '{2'd0, 4'd0, 1'b1, 1'b1, 32'hFFFF_8000, 32'h0, 16'h8000, 32'h0, 1'b0, 1'b0, 8'd7},       // R7
        '{2'd0, 4'd6, 1'b1, 1'b0, 32'h0000_7FFF, 32'h0, 16'h8000, 32'h1, 1'b0, 1'b0, 8'd6},       // R6
        '{2'd0, 4'd4, 1'b1, 1'b0, 32'h0, 32'h0, 16'h8000, 32'h1, 1'b0, 1'b0, 8'd5},               // R5
        '{2'd0, 4'd3, 1'b1, 1'b0, 32'h0000_7FFF, 32'h0, 16'h7FFF, 32'h1, 1'b0, 1'b0, 8'd5},       // R5
        '{2'd1, 4'd1, 1'b0, 1'b0, 32'h1, 32'h2, 16'h0, 32'h0, 1'b1, 1'b0, 8'd9},                  // R9
        '{2'd1, 4'd8, 1'b0, 1'b0, 32'h1, 32'h2, 16'h0, 32'h0, 1'b0, 1'b0, 8'd9},                  // R9
        '{2'd2, 4'd1, 1'b0, 1'b0, 32'h5, 32'h5, 16'h0, 32'h0, 1'b0, 1'b1, 8'd8},                  // R8
        '{2'd2, 4'd0, 1'b0, 1'b0, 32'h0, 32'h7, 16'h7, 32'h0, 1'b0, 1'b1, 8'd8},                  // R8
        '{2'd2, 4'd2, 1'b0, 1'b0, 32'h8000_0000, 32'h0, 16'h0, 32'h0, 1'b0, 1'b1, 8'd8},          // R8
        '{2'd0, 4'd12, 1'b0, 1'b0, 32'h3, 32'h3, 16'h0, 32'h0, 1'b0, 1'b0, 8'd2},                 // R2
        '{2'd3, 4'd0, 1'b0, 1'b0, 32'h3, 32'h3, 16'h0, 32'h0, 1'b0, 1'b0, 8'd12},                 // R12
        '{2'd0, 4'd5, 1'b1, 1'b1, 32'h0, 32'h0, 16'h8000, 32'h1, 1'b0, 1'b0, 8'd5}                // R5
    };

    localparam logic [31:0] VALS [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
    localparam logic [15:0] IMMS [5] = '{16'h7FFF, 16'h8000, 16'h0, 16'h1, 16'hFFFF};

    // Bench model written from the requirements
    function automatic logic [33:0] model(input logic [1:0] c, input logic [3:0] k,
                                          input logic ie, input logic iu,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [15:0] im);
        logic [31:0] rhs;
        logic        zx;
        logic        h;
        zx = (k >= 4'd6 && k <= 4'd9) || (k <= 4'd1 && iu);
        if (c == 2'd2)   rhs = 32'h0;
        else if (ie)     rhs = zx ? {16'h0, im} : {{16{im[15]}}, im};
        else             rhs = b;
        case (k)
            4'd0: h = (a == rhs);
            4'd1: h = (a != rhs);
            4'd2: h = ($signed(a) <  $signed(rhs));
            4'd3: h = ($signed(a) <= $signed(rhs));
            4'd4: h = ($signed(a) >  $signed(rhs));
            4'd5: h = ($signed(a) >= $signed(rhs));
            4'd6: h = (a <  rhs);
            4'd7: h = (a <= rhs);
            4'd8: h = (a >  rhs);
            4'd9: h = (a >= rhs);
            default: h = 1'b0;
        endcase
        case (c)
            2'd0:    model = {31'h0, h, 1'b0, 1'b0};
            2'd1:    model = {32'h0, h, 1'b0};
            2'd2:    model = {32'h0, 1'b0, h};
            default: model = '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual res=%h trap=%b br=%b, expected res=%h trap=%b br=%b",
                     tag, act[33:2], act[1], act[0], exp[33:2], exp[1], exp[0]);
        end
    endtask

    // Drive on a falling edge; the registered result is compared one rising edge later
    task automatic run(input string tag, input logic [1:0] c, input logic [3:0] k,
                       input logic ie, input logic iu, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input logic [33:0] exp);
        @(negedge clk);
        cls = c; cond = k; imm_en = ie; imm_uns = iu; opa = a; opb = b; imm = im;
        @(negedge clk);
        check(tag, {res, trap, br}, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cls = 2'd0; cond = 4'd0; imm_en = 1'b0; imm_uns = 1'b0;
        opa = 32'h0; opb = 32'h0; imm = 16'h0;
        repeat (3) @(negedge clk);
        check("R11 reset", {res, trap, br}, 34'h0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = TBL[i];
            run($sformatf("R%0d table row %0d", v.req, i), v.cls, v.cond, v.ie, v.iu,
                v.a, v.b, v.imm, {v.exp_res, v.exp_trap, v.exp_br});
        end

        // R1 R2 R3 R4 R9 R10: register form, set and trap, every code on boundary values
        for (int c = 0; c < 2; c++)
            for (int k = 0; k < 16; k++)
                for (int i = 0; i < 5; i++)
                    for (int j = 0; j < 5; j++)
                        run($sformatf("R1/R3/R4/R9/R10 reg cls=%0d code=%0d", c, k),
                            2'(c), 4'(k), 1'b0, 1'b0, VALS[i], VALS[j], 16'h0,
                            model(2'(c), 4'(k), 1'b0, 1'b0, VALS[i], VALS[j], 16'h0));

        // R5 R6 R7: immediate form with both extension flags
        for (int k = 0; k < 10; k++)
            for (int u = 0; u < 2; u++)
                for (int i = 0; i < 5; i++)
                    for (int j = 0; j < 5; j++)
                        run($sformatf("R5/R6/R7 imm code=%0d uns=%0d", k, u),
                            2'd0, 4'(k), 1'b1, 1'(u), VALS[i], 32'hDEAD_BEEF, IMMS[j],
                            model(2'd0, 4'(k), 1'b1, 1'(u), VALS[i], 32'hDEAD_BEEF, IMMS[j]));

        // R8: branch against zero, second operand ignored
        for (int k = 0; k < 10; k++)
            for (int i = 0; i < 5; i++)
                run($sformatf("R8 branch code=%0d", k), 2'd2, 4'(k), 1'b1, 1'b0,
                    VALS[i], VALS[4-i], 16'h8000,
                    model(2'd2, 4'(k), 1'b0, 1'b0, VALS[i], 32'h0, 16'h0));

        // R12: class 3 is quiet even when the relation holds
        run("R12 none ge", 2'd3, 4'd5, 1'b0, 1'b0, 32'h1, 32'h0, 16'h0, 34'h0);

        // R11: result appears exactly one rising edge after the stimulus
        @(negedge clk);
        cls = 2'd0; cond = 4'd0; imm_en = 1'b0; opa = 32'h9; opb = 32'h9;
        #1 check("R11 not before edge", {res, trap, br}, 34'h0);
        @(negedge clk);
        check("R11 after edge", {res, trap, br}, {32'h1, 2'b00});

        // R11: asynchronous reset clears outputs without a clock
        #2 rst_n = 1'b0;
        #1 check("R11 async reset", {res, trap, br}, 34'h0);
        @(negedge clk);
        rst_n = 1'b1;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule